// File: doc/BRIEF.md
# Sorted-Bit Serializer

The block takes a parallel data word together with a load strobe and replays that word's bits on one serial line, one bit per clock, already sorted. Every set bit comes out in one contiguous run and every clear bit in another. The stream is therefore a thermometer code, and the length of its run of ones equals the population count of the loaded word.

The word itself is not stored. At the load edge an adder tree counts the set bits. A run counter then holds the length of the leading run, and a slot counter frames exactly `WIDTH` output bits. A mode input, sampled with the load, chooses whether the ones or the zeros come first. Framing outputs mark the valid window, the first slot and the last slot.

A new load during a stream abandons the current stream and starts over with the new word. When no stream is running, the block is idle and drives the serial line low.

Top module: `bit_sort_serializer`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to idle: in the next cycle `out_valid`, `ser_out`, `first` and `last` are all 0.
- R2: When `load` is high at a rising edge, a stream of exactly `WIDTH` (default 32) slots follows. Slot k is presented in the k-th cycle after that edge (k = 0 … WIDTH-1), with `out_valid` high for all of them.
- R3: With `ones_first`=1 captured at load, `ser_out` is 1 for slots k < P and 0 for slots k ≥ P, where P is the number of set bits in the loaded word.
- R4: With `ones_first`=0 captured at load, `ser_out` is 1 exactly for slots k ≥ WIDTH − P.
- R5: Over one uninterrupted stream, the number of slots with `ser_out`=1 equals P in either mode.
- R6: `first` is high only in slot 0 and `last` only in slot WIDTH−1. Neither is high outside a stream.
- R7: After slot WIDTH−1, with no new load, the block is idle: `out_valid`=0 and `ser_out`=0.
- R8: A load during a stream aborts it. The next cycle is slot 0 of a new stream built from the newly sampled word and mode.
- R9: Changes on `data_in` or `ones_first` without `load` have no effect on a running stream.
- R10: An all-zero word gives WIDTH zeros and an all-ones word gives WIDTH ones, in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture `data_in` and `ones_first`, then start a stream |
| data_in | input | WIDTH | Parallel word to be sorted |
| ones_first | input | 1 | 1: ones run leads; 0: zeros run leads |
| ser_out | output | 1 | Sorted serial bit |
| out_valid | output | 1 | High during the WIDTH slots of a stream |
| first | output | 1 | High in slot 0 |
| last | output | 1 | High in slot WIDTH−1 |

## Verification
All outputs come straight from registers loaded at the load edge, so slot k is due k cycles after the edge that sampled `load` and stays steady for the whole cycle. The bench drives inputs on the falling edge and reads outputs on the next falling edge. That way each read lands in the middle of the slot it checks. The idle check is due WIDTH cycles after the load edge. The abort check is due one cycle after the second load edge, when slot 0 of the new word must appear. The reset check is due one cycle after `rst` is sampled.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

   typedef enum logic {
      LEAD_ZEROS = 1'b0,
      LEAD_ONES  = 1'b1
   } lead_e;

   // Width of a counter that must hold values 0..max_val
   function automatic int count_bits(input int max_val);
      int n;
      n = 1;
      while ((1 << n) <= max_val) n++;
      return n;
   endfunction

endpackage

// File: rtl/bsort_popcount.sv
module bsort_popcount #(
   parameter int WIDTH    = 32,
   parameter int CNT_W    = 6,
   parameter bit TREE_ADD = 1'b1
) (
   input  logic [WIDTH-1:0] data,
   output logic [CNT_W-1:0] count
);

   localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;
   localparam int LEAVES = 1 << LEVELS;

   generate
      if (CNT_W < $clog2(WIDTH + 1)) begin : g_bad_cnt
         $error("bsort_popcount: CNT_W too narrow for WIDTH");
      end

      if (TREE_ADD) begin : g_tree
         for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
            localparam int N = LEAVES >> l;
            logic [CNT_W-1:0] s [N];
            if (l == 0) begin : g_leaf
               for (genvar i = 0; i < N; i++) begin : g_in
                  if (i < WIDTH) begin : g_real
                     assign s[i] = CNT_W'(data[i]);
                  end else begin : g_pad
                     assign s[i] = '0;
                  end
               end
            end else begin : g_node
               for (genvar i = 0; i < N; i++) begin : g_add
                  assign s[i] = g_lvl[l-1].s[2*i] + g_lvl[l-1].s[2*i+1];
               end
            end
         end
         assign count = g_lvl[LEVELS].s[0];
      end else begin : g_chain
         always_comb begin
            count = '0;
            for (int i = 0; i < WIDTH; i++) begin
               count = count + CNT_W'(data[i]);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/bsort_slot_framer.sv
module bsort_slot_framer #(
   parameter int WIDTH  = 32,
   parameter int SLOT_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   output logic              active,
   output logic [SLOT_W-1:0] slot,
   output logic              first,
   output logic              last
);

   localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(WIDTH - 1);

   generate
      if ((1 << SLOT_W) < WIDTH) begin : g_bad_slot
         $error("bsort_slot_framer: SLOT_W too narrow for WIDTH");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         slot   <= '0;
      end else if (load) begin
         active <= 1'b1;
         slot   <= '0;
      end else if (active) begin
         if (slot == SLOT_END) begin
            active <= 1'b0;
            slot   <= '0;
         end else begin
            slot <= slot + 1'b1;
         end
      end
   end

   assign first = active && (slot == '0);
   assign last  = active && (slot == SLOT_END);

endmodule

// File: rtl/bsort_run_counter.sv
module bsort_run_counter
   import bsort_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             ones_first,
   input  logic [CNT_W-1:0] pop,
   input  logic             active,
   output logic             bit_out,
   output lead_e            lead
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(WIDTH);

   logic [CNT_W-1:0] run_left;
   logic [CNT_W-1:0] run_init;

   // Leading run length: ones in ones-first mode, zeros otherwise
   assign run_init = ones_first ? pop : (FULL - pop);

   always_ff @(posedge clk) begin
      if (rst) begin
         run_left <= '0;
         lead     <= LEAD_ZEROS;
      end else if (load) begin
         run_left <= run_init;
         lead     <= ones_first ? LEAD_ONES : LEAD_ZEROS;
      end else if (active && (run_left != '0)) begin
         run_left <= run_left - 1'b1;
      end
   end

   always_comb begin
      if (!active)               bit_out = 1'b0;
      else if (run_left != '0)   bit_out = lead;
      else                       bit_out = ~lead;
   end

endmodule

// File: rtl/bit_sort_serializer.sv
module bit_sort_serializer
   import bsort_pkg::*;
#(
   parameter int WIDTH    = 32,
   parameter bit TREE_ADD = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] data_in,
   input  logic             ones_first,
   output logic             ser_out,
   output logic             out_valid,
   output logic             first,
   output logic             last
);

   localparam int CNT_W  = count_bits(WIDTH);
   localparam int SLOT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bit_sort_serializer: WIDTH must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0]  pop_cnt;
   logic              stream_on;
   logic [SLOT_W-1:0] slot_idx;
   lead_e             lead_q;

   bsort_popcount #(
      .WIDTH   (WIDTH),
      .CNT_W   (CNT_W),
      .TREE_ADD(TREE_ADD)
   ) u_pop (
      .data (data_in),
      .count(pop_cnt)
   );

   bsort_slot_framer #(
      .WIDTH (WIDTH),
      .SLOT_W(SLOT_W)
   ) u_frame (
      .clk   (clk),
      .rst   (rst),
      .load  (load),
      .active(stream_on),
      .slot  (slot_idx),
      .first (first),
      .last  (last)
   );

   bsort_run_counter #(
      .WIDTH(WIDTH),
      .CNT_W(CNT_W)
   ) u_run (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .ones_first(ones_first),
      .pop       (pop_cnt),
      .active    (stream_on),
      .bit_out   (ser_out),
      .lead      (lead_q)
   );

   assign out_valid = stream_on;

endmodule

// File: rtl/bsort_checker.sv
module bsort_checker (
   input logic clk,
   input logic rst,
   input logic load,
   input logic ser_out,
   input logic out_valid,
   input logic first,
   input logic last,
   input logic lead_bit
);

   // R1: reset returns the block to idle
   assert_reset_idle_R1: assert property (@(posedge clk)
      rst |=> (!out_valid && !ser_out && !first && !last));

   // R2: a stream continues until its last slot
   assert_stream_holds_R2: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !last && !load) |=> out_valid);

   // R7: the stream ends after the last slot
   assert_idle_after_last_R7: assert property (@(posedge clk) disable iff (rst)
      (last && !load) |=> !out_valid);

   assert_idle_low_R7: assert property (@(posedge clk)
      !out_valid |-> !ser_out);

   // R8: a load always starts at slot 0
   assert_load_restart_R8: assert property (@(posedge clk) disable iff (rst)
      load |=> (first && out_valid));

   // R6: framing marks only inside a stream, never both
   assert_frame_marks_R6: assert property (@(posedge clk)
      ((first || last) |-> out_valid) && $onehot0({first, last}));

   // R3: in ones-first mode, once the line drops it stays low
   assert_ones_mono_R3: assert property (@(posedge clk) disable iff (rst)
      (out_valid && lead_bit && !ser_out && !last && !load) |=> !ser_out);

   // R4: in zeros-first mode, once the line rises it stays high
   assert_zeros_mono_R4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !lead_bit && ser_out && !last && !load) |=> ser_out);

endmodule

bind bit_sort_serializer bsort_checker u_chk (
   .clk      (clk),
   .rst      (rst),
   .load     (load),
   .ser_out  (ser_out),
   .out_valid(out_valid),
   .first    (first),
   .last     (last),
   .lead_bit (lead_q)
);

// File: tb/tb_bit_sort_serializer.sv
module tb_bit_sort_serializer;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         load = 1'b0;
   logic [W-1:0] data_in = '0;
   logic         ones_first = 1'b0;
   logic         ser_out, out_valid, first, last;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   bit_sort_serializer #(.WIDTH(W)) dut (
      .clk(clk), .rst(rst), .load(load), .data_in(data_in),
      .ones_first(ones_first), .ser_out(ser_out), .out_valid(out_valid),
      .first(first), .last(last)
   );

   function automatic int popc(input logic [W-1:0] v);
      int c = 0;
      for (int i = 0; i < W; i++) c += int'(v[i]);
      return c;
   endfunction

   function automatic logic exp_bit(input int k, input int p, input logic of);
      return of ? (k < p) : (k >= W - p);
   endfunction

   task automatic chk(input string req, input logic act, input logic exp, input string what);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   task automatic do_load(input logic [W-1:0] v, input logic of);
      load = 1'b1; data_in = v; ones_first = of;
      @(negedge clk);
      load = 1'b0;
   endtask

   // Check slots from `from` to `upto`-1; wiggle inputs without load (R9)
   task automatic watch(input logic [W-1:0] v, input logic of, input int from,
                        input int upto, input string req);
      int p = popc(v);
      for (int k = from; k < upto; k++) begin
         chk("R2", out_valid, 1'b1, $sformatf("valid slot %0d", k));
         chk(req, ser_out, exp_bit(k, p, of), $sformatf("bit slot %0d", k));
         chk("R6", first, (k == 0), $sformatf("first slot %0d", k));
         chk("R6", last, (k == W - 1), $sformatf("last slot %0d", k));
         data_in = $urandom; ones_first = $urandom;
         if (k + 1 < upto) @(negedge clk);
      end
   endtask

   task automatic full_stream(input logic [W-1:0] v, input logic of, input string req);
      int ones = 0;
      int p = popc(v);
      do_load(v, of);
      for (int k = 0; k < W; k++) begin
         chk("R2", out_valid, 1'b1, $sformatf("valid slot %0d", k));
         chk(req, ser_out, exp_bit(k, p, of), $sformatf("bit slot %0d", k));
         chk("R6", first, (k == 0), "first");
         chk("R6", last, (k == W - 1), "last");
         ones += int'(ser_out);
         data_in = $urandom; ones_first = $urandom;  // R9: no load, no effect
         @(negedge clk);
      end
      n_checks++;
      if (ones != p) begin
         n_fail++;
         $display("FAIL R5 ones in stream: actual %0d expected %0d", ones, p);
      end
      chk("R7", out_valid, 1'b0, "idle valid");
      chk("R7", ser_out, 1'b0, "idle line");
      chk("R6", first | last, 1'b0, "idle marks");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240517));
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
      // R1: state after reset
      chk("R1", out_valid, 1'b0, "reset valid");
      chk("R1", ser_out, 1'b0, "reset line");
      chk("R1", first | last, 1'b0, "reset marks");

      // R10: all-zero and all-ones corners in both modes
      full_stream('0, 1'b1, "R10");
      full_stream('0, 1'b0, "R10");
      full_stream('1, 1'b1, "R10");
      full_stream('1, 1'b0, "R10");
      // R3 / R4 directed: single bit, W-1 bits
      full_stream(32'h0000_0400, 1'b1, "R3");
      full_stream(32'h0000_0400, 1'b0, "R4");
      full_stream(32'hFFFF_FFFE, 1'b1, "R3");
      full_stream(32'hFFFF_FFFE, 1'b0, "R4");

      // Random words of varying density
      for (int t = 0; t < 40; t++) begin
         logic [W-1:0] v;
         logic of;
         case (t % 4)
            0: v = $urandom;
            1: v = $urandom & $urandom & $urandom;
            2: v = $urandom | $urandom;
            default: v = $urandom & $urandom;
         endcase
         of = $urandom;
         full_stream(v, of, of ? "R3" : "R4");
      end

      // R8: abort mid-stream with a new word and mode
      for (int t = 0; t < 6; t++) begin
         logic [W-1:0] a = $urandom;
         logic [W-1:0] b = $urandom & $urandom;
         int cut = 1 + ($urandom % (W - 1));
         do_load(a, 1'b1);
         watch(a, 1'b1, 0, cut, "R3");
         @(negedge clk);
         do_load(b, 1'b0);
         chk("R8", first, 1'b1, "restart first");
         chk("R8", ser_out, exp_bit(0, popc(b), 1'b0), "restart bit 0");
         watch(b, 1'b0, 0, W, "R8");
         @(negedge clk);
         chk("R7", out_valid, 1'b0, "idle after restart");
      end

      // R1: reset in the middle of a stream
      do_load(32'hF0F0_1234, 1'b1);
      @(negedge clk); @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1", out_valid, 1'b0, "mid reset valid");
      chk("R1", ser_out, 1'b0, "mid reset line");
      chk("R1", first | last, 1'b0, "mid reset marks");
      @(negedge clk);
      chk("R7", out_valid, 1'b0, "stays idle");

      finish_run();
   end

endmodule